// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when a timer counter advances. It emits a single-cycle enable, `tick_o`, that the counter uses as a count enable in the system clock domain. A 3-bit source code picks the tick source. One code halts the timer. One code ticks on every clock. Four codes tick once per 8, 64, 256 or 1024 clocks. The last two codes tick on a falling or a rising edge of an external count pin.

The divided rates come from one free-running prescaler counter that all four ratios share. Reset clears it, and a change of the source code does not restart it. The external pin is asynchronous. It passes through a synchronizer chain and then an edge detector, so each accepted edge yields exactly one tick.

The output is always a registered enable pulse in the system clock domain, never a derived clock. As a worked rate, an 8 MHz system clock with the 1024 ratio gives roughly 7812 ticks per second, about one every 128 µs. An 8-bit counter driven by it then wraps about every 32.8 ms.

Top module: `tmr_tick_gen`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is low. Reset clears the prescaler, so in a divided mode `tick_o` is high in the first cycle after the first rising clock edge following reset release.
- R2: Source code 3'b000 produces no ticks, whatever the external pin does.
- R3: Source code 3'b001 makes `tick_o` high in every cycle, one clock after the code is sampled.
- R4: Source codes 3'b010, 3'b011, 3'b100 and 3'b101 give one single-cycle tick per 8, 64, 256 and 1024 clocks. A tick follows each clock edge at which the free-running prescaler count, zero at the first edge after reset, is a multiple of the ratio.
- R5: The prescaler keeps counting across source-code changes, so the phase of the divided ticks follows the clock edges counted since reset, not the moment of the switch.
- R6: Source code 3'b110 ticks once for each falling edge of `ext_pin_i`. The pin goes through two synchronizer flops, so the tick is high after the third rising clock edge at which the new pin level is sampled.
- R7: Source code 3'b111 ticks once for each rising edge of `ext_pin_i`, with the same latency as R6.
- R8: Reset clears the synchronizer to low. A pin held high through reset therefore counts as one rising edge after release, and not as a falling edge.
- R9: Each external edge gives a tick exactly one cycle wide. A pin held at a steady level gives no further ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Tick source code |
| ext_pin_i | input | 1 | Asynchronous external count input |
| tick_o | output | 1 | Registered single-cycle count enable |

## Verification
A prescaler in the wrong state shows up at `tick_o` as a shifted tick phase. In divide-by-8 mode this appears within eight cycles. In divide-by-1024 mode it can take up to 1024 cycles, which is why the bench compares every cycle against a model driven by the edges counted since reset. A wrong synchronizer or edge-history state shows up as a missing, doubled or wrong-polarity tick three edges after a pin transition. The bench drives narrow pulses, long holds and a pin held high through reset to bring these cases out.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

   // source codes; the numeric values are decoded by the top mux
   typedef enum logic [2:0] {
      SRC_HALT     = 3'b000,
      SRC_DIV1     = 3'b001,
      SRC_DIV8     = 3'b010,
      SRC_DIV64    = 3'b011,
      SRC_DIV256   = 3'b100,
      SRC_DIV1024  = 3'b101,
      SRC_EXT_FALL = 3'b110,
      SRC_EXT_RISE = 3'b111
   } tick_src_e;

   localparam int unsigned NUM_TAPS = 4;

   typedef int unsigned tap_list_t [NUM_TAPS];

   // log2 of the division ratios, ascending
   localparam tap_list_t DEFAULT_TAP_LOG2 = '{3, 6, 8, 10};

endpackage

// File: rtl/tmr_tick_prescaler.sv
module tmr_tick_prescaler
   import tmr_tick_pkg::*;
#(
   parameter int unsigned CNT_W    = 10,
   parameter tap_list_t   TAP_LOG2 = DEFAULT_TAP_LOG2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   output logic [NUM_TAPS-1:0] tap_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;

   // elaboration-time parameter checks
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("tmr_tick_prescaler: CNT_W must be at least 1");
      end
      for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap_chk
         if (TAP_LOG2[t] > CNT_W || TAP_LOG2[t] < 1) begin : g_bad_tap
            $error("tmr_tick_prescaler: tap exceeds counter width");
         end
         if (t > 0) begin : g_order
            if (TAP_LOG2[t] <= TAP_LOG2[t-1]) begin : g_bad_order
               $error("tmr_tick_prescaler: taps must ascend");
            end
         end
      end
   endgenerate

   // free-running counter, never reloaded except by reset
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   // one decode per ratio: low bits all zero
   generate
      for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
         localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << TAP_LOG2[t]) - 64'd1);
         assign tap_o[t] = ((cnt_q & MASK) == '0);
      end
   endgenerate

   // R4
   fastest_tap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_o[0] |=> !tap_o[0]);

   generate
      for (genvar t = 1; t < NUM_TAPS; t++) begin : g_nest_chk
         // R4
         tap_nesting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tap_o[t] |-> tap_o[t-1]);
      end
   endgenerate

endmodule

// File: rtl/tmr_tick_extsync.sv
module tmr_tick_extsync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   level;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("tmr_tick_extsync: need at least two synchronizer stages");
      end
   endgenerate

   // synchronizer chain, stage 0 samples the pin
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
      end else begin
         sync_q[0] <= pin_i;
         for (int s = 1; s < SYNC_STAGES; s++) begin
            sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign level = sync_q[SYNC_STAGES-1];

   // one-flop history for edge detection
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= level;
      end
   end

   assign rise_o = level & ~prev_q;
   assign fall_o = ~level & prev_q;

   // R6 R7
   edge_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_o && fall_o));

   // R9
   rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

   // R9
   fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |=> !fall_o);

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
   import tmr_tick_pkg::*;
#(
   parameter int unsigned PRESC_W     = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter tap_list_t   TAP_LOG2    = DEFAULT_TAP_LOG2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] sel_i,
   input  logic       ext_pin_i,
   output logic       tick_o
);

   tick_src_e           src;
   logic [NUM_TAPS-1:0] tap;
   logic                ext_rise;
   logic                ext_fall;
   logic                tick_d;
   logic                tick_q;

   assign src = tick_src_e'(sel_i);

   tmr_tick_prescaler #(
      .CNT_W    (PRESC_W),
      .TAP_LOG2 (TAP_LOG2)
   ) presc_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tap_o  (tap)
   );

   tmr_tick_extsync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) ext_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_pin_i),
      .rise_o (ext_rise),
      .fall_o (ext_fall)
   );

   // source mux
   always_comb begin
      unique case (src)
         SRC_HALT:     tick_d = 1'b0;
         SRC_DIV1:     tick_d = 1'b1;
         SRC_DIV8:     tick_d = tap[0];
         SRC_DIV64:    tick_d = tap[1];
         SRC_DIV256:   tick_d = tap[2];
         SRC_DIV1024:  tick_d = tap[3];
         SRC_EXT_FALL: tick_d = ext_fall;
         SRC_EXT_RISE: tick_d = ext_rise;
         default:      tick_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tick_q <= 1'b0;
      end else begin
         tick_q <= tick_d;
      end
   end

   assign tick_o = tick_q;

   // R2
   halt_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'b000) |=> !tick_o);

   // R3
   div1_every_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'b001) |=> tick_o);

   // R7
   rise_to_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'b111 && ext_rise) |=> tick_o);

   // R6
   fall_to_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'b110 && ext_fall) |=> tick_o);

   // R4
   div8_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'b010 && $past(sel_i) == 3'b010 && tick_o) |=> !tick_o);

endmodule

// File: tb/tmr_tick_gen_tb_top.sv
module tmr_tick_gen_tb_top;

   typedef struct {
      logic  val;
      string tag;
   } exp_item_t;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [2:0] sel_i = 3'b000;
   logic       ext_pin_i = 1'b0;
   logic       tick_o;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   bit          done = 1'b0;

   exp_item_t   sb_q [$];

   // model state: edges since reset, pin levels at the last three edges
   int unsigned m_cnt = 0;
   logic        m_p1 = 1'b0;
   logic        m_p2 = 1'b0;
   logic        m_p3 = 1'b0;
   exp_item_t   m_it;
   exp_item_t   mon_it;

   tmr_tick_gen dut_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (sel_i),
      .ext_pin_i (ext_pin_i),
      .tick_o    (tick_o)
   );

   always #4 clk_i = ~clk_i;

   task automatic check(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: tick_o actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_cnt(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: tick count actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // driver side: expected values from the requirements
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         m_cnt = 0;
         m_p1 = 1'b0; m_p2 = 1'b0; m_p3 = 1'b0;
         m_it.val = 1'b0;
         m_it.tag = "R1";
      end else begin
         case (sel_i)
            3'b000: begin m_it.val = 1'b0; m_it.tag = "R2"; end
            3'b001: begin m_it.val = 1'b1; m_it.tag = "R3"; end
            3'b010: begin m_it.val = (m_cnt % 8 == 0);    m_it.tag = "R4"; end
            3'b011: begin m_it.val = (m_cnt % 64 == 0);   m_it.tag = "R4"; end
            3'b100: begin m_it.val = (m_cnt % 256 == 0);  m_it.tag = "R4"; end
            3'b101: begin m_it.val = (m_cnt % 1024 == 0); m_it.tag = "R4"; end
            3'b110: begin m_it.val = (!m_p2 && m_p3); m_it.tag = "R6"; end
            default: begin m_it.val = (m_p2 && !m_p3); m_it.tag = "R7"; end
         endcase
         m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_pin_i;
         m_cnt = m_cnt + 1;
      end
      sb_q.push_back(m_it);
   end

   // monitor side
   always @(negedge clk_i) begin
      if (sb_q.size() > 0) begin
         mon_it = sb_q.pop_front();
         check(mon_it.tag, tick_o, mon_it.val);
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk_i);
   endtask

   task automatic count_ticks(input int n, output int c);
      c = 0;
      repeat (n) begin
         @(negedge clk_i);
         if (tick_o === 1'b1) c++;
      end
   endtask

   task automatic pulse_pin(input logic lvl, input int width, input int gap);
      ext_pin_i = lvl;
      cycles(width);
      ext_pin_i = ~lvl;
      cycles(gap);
   endtask

   initial begin
      int c;
      // R8: pin high through reset, rising-edge mode
      sel_i = 3'b111;
      ext_pin_i = 1'b1;
      cycles(5);
      check("R1", tick_o, 1'b0);
      rst_ni = 1'b1;
      count_ticks(8, c);
      check_cnt("R8", c, 1);

      // R2: halted while pin toggles
      sel_i = 3'b000;
      for (int i = 0; i < 10; i++) pulse_pin(1'b0, 2, 3);
      count_ticks(40, c);
      check_cnt("R2", c, 0);

      // R3
      sel_i = 3'b001;
      count_ticks(50, c);
      check_cnt("R3", c, 50);

      // R4: each ratio, two full periods
      sel_i = 3'b010;  count_ticks(16, c);   check_cnt("R4", c, 2);
      sel_i = 3'b011;  count_ticks(128, c);  check_cnt("R4", c, 2);
      sel_i = 3'b100;  count_ticks(512, c);  check_cnt("R4", c, 2);
      sel_i = 3'b101;  count_ticks(2048, c); check_cnt("R4", c, 2);

      // R5: switching between ratios mid-period keeps the phase
      for (int i = 0; i < 6; i++) begin
         sel_i = 3'b010 + 3'(i % 4);
         cycles(37 + 11 * i);
      end
      sel_i = 3'b010;
      cycles(100);

      // R6: falling edges of different widths
      sel_i = 3'b110;
      ext_pin_i = 1'b1;
      cycles(6);
      count_ticks(6, c);
      check_cnt("R6", c, 0);
      for (int w = 1; w < 5; w++) pulse_pin(1'b0, w, 6);
      ext_pin_i = 1'b0;
      count_ticks(8, c);
      check_cnt("R6", c, 1);

      // R7 and R9: rise then long hold gives one tick only
      sel_i = 3'b111;
      ext_pin_i = 1'b1;
      count_ticks(30, c);
      check_cnt("R9", c, 1);
      ext_pin_i = 1'b0;
      cycles(6);
      for (int w = 1; w < 5; w++) pulse_pin(1'b1, w, 5);
      for (int i = 0; i < 8; i++) begin
         ext_pin_i = ~ext_pin_i;
         cycles(1);
      end
      cycles(8);

      // R1: mid-run reset, first divided tick right after release
      sel_i = 3'b011;
      cycles(13);
      rst_ni = 1'b0;
      ext_pin_i = 1'b0;
      cycles(3);
      check("R1", tick_o, 1'b0);
      rst_ni = 1'b1;
      cycles(1);
      check("R1", tick_o, 1'b1);
      cycles(140);

      cycles(2);
      done = 1'b1;
   end

   // watchdog and summary
   initial begin
      fork
         wait (done == 1'b1);
         begin
            repeat (150000) @(posedge clk_i);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual timeout expected done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule